// File: doc/BRIEF.md
# Bridge Secondary-Bus Data Error Reporter

This block sits in the downstream path of a PCIe-to-PCI/PCI-X bridge. It decides what gets reported when a forwarded request runs into bad data on the secondary bus. The two cases are:

- a data error found while taking in a read or split response;
- the parity-error pin driven by the target during a non-posted write.

Each event updates a set of sticky status bits. Each status bit has its own gating by the parity-response enable, the error mask, the error severity, and the state of the first-error pointer. Unmasked events can capture the request header into a log. The block can also raise a fatal or non-fatal message request that stays up until acknowledged. Finally, it shapes the completion that goes back to the requester.

A read that saw bad data is not cut short. When the transfer ends, the completion is returned with Successful status and the poison flag set. A write that the target finished with a data transfer after flagging parity is answered with Unsupported Request. The status bits are cleared by write-one-to-clear strobes. Serialising the message and decoding register accesses are handled by neighbouring logic.

Top module: `sec_data_err_rpt`

## Requirements
- R1: After reset, every output is low:
  - all status bits;
  - the pointer valid flag and the pointer index;
  - the header log;
  - the parity pin drive;
  - the message request;
  - all completion outputs.
- R2: A read error (`rd_err_i`) always sets these status bits, one cycle later:
  - detected parity (bit 1);
  - uncorrectable data (bit 2);
  - fatal-detected (bit 5) if `ude_sev_i` is 1, otherwise non-fatal-detected (bit 6).

  It also has two effects that apply only when `perr_rsp_en_i` is 1:
  - it sets master data parity (bit 0);
  - it drives `perr_o` high for exactly the cycle after the error.
- R3: A write parity event (`wr_perr_i`) has these effects:
  - it always sets address/data parity (bit 3);
  - it sets bit 5 or bit 6 according to `adpe_sev_i`;
  - it sets bit 0 only when `perr_rsp_en_i` is 1;
  - it never drives `perr_o`.
- R4: When the first-error pointer is not valid, an unmasked error captures `hdr_i` into `hdr_log_o` and makes the pointer valid. The pointer index is 0 for a read error and 1 for a write error. If both arrive in the same cycle, the read error wins. While the pointer is valid, the log and the index hold.
- R5: An error requests a message only when its mask bit is 0 and either `serr_en_i` is set or the reporting enable for its severity is set (`fatal_rpt_en_i` or `nonfatal_rpt_en_i`).
  - `msg_req_o` rises the next cycle and stays high until a cycle with `msg_ack_i`.
  - `msg_fatal_o` is 1 if any generated message since the request was raised was fatal.
  - A new message in the same cycle as an acknowledge starts a fresh request.
- R6: Signalled-system-error (bit 4) is set only in a cycle in which a message is generated while `serr_en_i` is 1.
- R7: `sts_clr_i[k]` clears status bit k one cycle later. A set in the same cycle wins over the clear.
- R8: A clear strobe on the status bit that the pointer names (bit 2 for index 0, bit 3 for index 1) makes the pointer invalid. In that same cycle a new unmasked error may capture.
- R9: A read error alone produces no completion. `rd_done_i` produces `cpl_vld_o` the next cycle, with `cpl_ur_o` at 0 and `cpl_poison_o` at 1 if any read error occurred since the previous read completion (including the `rd_done_i` cycle). `rd_done_i` and `wr_done_i` are never high together.
- R10: A read error does not carry over: the completion after the poisoned one is clean unless it sees a new error.
- R11: `wr_done_i` produces a completion the next cycle with `cpl_poison_o` at 0. `cpl_ur_o` is 1 only if a write parity event occurred since the previous write completion and `wr_data_xfer_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rd_err_i | input | 1 | data error pulse on read/split response |
| rd_done_i | input | 1 | read transfer ended |
| wr_perr_i | input | 1 | parity pin seen during non-posted write |
| wr_done_i | input | 1 | write transfer ended |
| wr_data_xfer_i | input | 1 | target completed write with a data transfer |
| hdr_i | input | HDR_W | header of the request in flight |
| perr_rsp_en_i | input | 1 | secondary parity-error response enable |
| serr_en_i | input | 1 | system error enable |
| fatal_rpt_en_i | input | 1 | fatal reporting enable |
| nonfatal_rpt_en_i | input | 1 | non-fatal reporting enable |
| ude_mask_i | input | 1 | mask for read data error |
| ude_sev_i | input | 1 | severity of read data error, 1 = fatal |
| adpe_mask_i | input | 1 | mask for write parity error |
| adpe_sev_i | input | 1 | severity of write parity error, 1 = fatal |
| sts_clr_i | input | 7 | write-one-to-clear strobes per status bit |
| msg_ack_i | input | 1 | message accepted |
| sts_o | output | 7 | sticky status bits |
| fep_vld_o | output | 1 | first-error pointer valid |
| fep_idx_o | output | 1 | first-error pointer, 0 read, 1 write |
| hdr_log_o | output | HDR_W | captured header |
| perr_o | output | 1 | secondary parity pin drive |
| msg_req_o | output | 1 | error message request |
| msg_fatal_o | output | 1 | requested message is fatal |
| cpl_vld_o | output | 1 | completion strobe |
| cpl_ur_o | output | 1 | completion status Unsupported Request |
| cpl_poison_o | output | 1 | completion poisoned |

## Verification
A wrong sticky bit shows on `sts_o` one cycle after the event or the clear. A stale or missed pointer shows on the next error, one cycle later: the header log either fails to follow a fresh capture or changes when it should hold. A stuck read-poison flag only shows at the next `rd_done_i`, when a clean completion arrives poisoned. The bench therefore compares every output against a cycle model on every cycle. It mixes random error, clear and acknowledge traffic with directed split-completion sequences.

// File: rtl/err_rpt_pkg.sv
package err_rpt_pkg;
  localparam int unsigned ST_N    = 7;
  localparam int unsigned ST_MDPE = 0;
  localparam int unsigned ST_DPE  = 1;
  localparam int unsigned ST_UDE  = 2;
  localparam int unsigned ST_ADPE = 3;
  localparam int unsigned ST_SSE  = 4;
  localparam int unsigned ST_FED  = 5;
  localparam int unsigned ST_NFED = 6;
  localparam int unsigned SRC_N   = 2;
  localparam int unsigned SRC_RD  = 0;
  localparam int unsigned SRC_WR  = 1;
endpackage

// File: rtl/err_sts_bank.sv
module err_sts_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R7
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/err_hdr_log.sv
module err_hdr_log
  import err_rpt_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] cap_i,
  input  logic [SRC_N-1:0] ptr_clr_i,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             fep_vld_o,
  output logic             fep_idx_o,
  output logic [HDR_W-1:0] hdr_o
);
  logic vld_eff, take, idx_d;

  // pointer drops when the bit it names is cleared
  assign vld_eff = fep_vld_o & ~ptr_clr_i[fep_idx_o];
  assign take    = ~vld_eff & (cap_i != '0);
  assign idx_d   = cap_i[SRC_RD] ? 1'(SRC_RD) : 1'(SRC_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fep_vld_o <= 1'b0;
      fep_idx_o <= 1'b0;
      hdr_o     <= '0;
    end else if (take) begin
      fep_vld_o <= 1'b1;
      fep_idx_o <= idx_d;
      hdr_o     <= hdr_i;
    end else begin
      fep_vld_o <= vld_eff;
    end
  end

  // R4
  log_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fep_vld_o && !ptr_clr_i[fep_idx_o]) |=> ($stable(hdr_o) && $stable(fep_idx_o) && fep_vld_o));
  // R8
  ptr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fep_vld_o && ptr_clr_i[fep_idx_o] && cap_i == '0) |=> !fep_vld_o);
endmodule

// File: rtl/err_msg_gen.sv
module err_msg_gen
  import err_rpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] ev_i,
  input  logic [SRC_N-1:0] mask_i,
  input  logic [SRC_N-1:0] sev_i,
  input  logic             serr_en_i,
  input  logic             fatal_en_i,
  input  logic             nonfatal_en_i,
  input  logic             ack_i,
  output logic             sse_set_o,
  output logic             req_o,
  output logic             fatal_o
);
  logic [SRC_N-1:0] gen;
  logic             any_gen, gen_fatal, keep;

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    assign gen[s] = ev_i[s] & ~mask_i[s] &
                    (serr_en_i | (sev_i[s] ? fatal_en_i : nonfatal_en_i));
  end

  assign any_gen   = gen != '0;
  assign gen_fatal = (gen & sev_i) != '0;
  assign sse_set_o = any_gen & serr_en_i;
  assign keep      = req_o & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      fatal_o <= 1'b0;
    end else if (any_gen) begin
      req_o   <= 1'b1;
      fatal_o <= (keep & fatal_o) | gen_fatal;
    end else if (ack_i) begin
      req_o   <= 1'b0;
      fatal_o <= 1'b0;
    end
  end

  // R5
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && (fatal_o || !$past(fatal_o))));
  // R5
  msg_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && ((ev_i & ~mask_i) == '0)) |=> !req_o);
endmodule

// File: rtl/err_cpl_track.sv
module err_cpl_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_err_i,
  input  logic rd_done_i,
  input  logic wr_perr_i,
  input  logic wr_done_i,
  input  logic wr_data_xfer_i,
  output logic cpl_vld_o,
  output logic cpl_ur_o,
  output logic cpl_poison_o
);
  logic rd_flag_q, wr_flag_q, rd_bad, wr_bad;

  assign rd_bad = rd_flag_q | rd_err_i;
  assign wr_bad = wr_flag_q | wr_perr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_flag_q    <= 1'b0;
      wr_flag_q    <= 1'b0;
      cpl_vld_o    <= 1'b0;
      cpl_ur_o     <= 1'b0;
      cpl_poison_o <= 1'b0;
    end else begin
      rd_flag_q    <= rd_done_i ? 1'b0 : rd_bad;
      wr_flag_q    <= wr_done_i ? 1'b0 : wr_bad;
      cpl_vld_o    <= rd_done_i | wr_done_i;
      cpl_poison_o <= rd_done_i & rd_bad;
      cpl_ur_o     <= ~rd_done_i & wr_done_i & wr_bad & wr_data_xfer_i;
    end
  end

  // R9
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_done_i && wr_done_i));
  // R9
  no_early_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_done_i && !wr_done_i) |=> !cpl_vld_o);
  // R11
  cpl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_vld_o |-> !(cpl_ur_o && cpl_poison_o));
endmodule

// File: rtl/sec_data_err_rpt.sv
module sec_data_err_rpt
  import err_rpt_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_err_i,
  input  logic             rd_done_i,
  input  logic             wr_perr_i,
  input  logic             wr_done_i,
  input  logic             wr_data_xfer_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             perr_rsp_en_i,
  input  logic             serr_en_i,
  input  logic             fatal_rpt_en_i,
  input  logic             nonfatal_rpt_en_i,
  input  logic             ude_mask_i,
  input  logic             ude_sev_i,
  input  logic             adpe_mask_i,
  input  logic             adpe_sev_i,
  input  logic [ST_N-1:0]  sts_clr_i,
  input  logic             msg_ack_i,
  output logic [ST_N-1:0]  sts_o,
  output logic             fep_vld_o,
  output logic             fep_idx_o,
  output logic [HDR_W-1:0] hdr_log_o,
  output logic             perr_o,
  output logic             msg_req_o,
  output logic             msg_fatal_o,
  output logic             cpl_vld_o,
  output logic             cpl_ur_o,
  output logic             cpl_poison_o
);
  logic [SRC_N-1:0] ev, mask, sev, ptr_clr;
  logic [ST_N-1:0]  sts_set;
  logic             sse_set;

  assign ev[SRC_RD]      = rd_err_i;
  assign ev[SRC_WR]      = wr_perr_i;
  assign mask[SRC_RD]    = ude_mask_i;
  assign mask[SRC_WR]    = adpe_mask_i;
  assign sev[SRC_RD]     = ude_sev_i;
  assign sev[SRC_WR]     = adpe_sev_i;
  assign ptr_clr[SRC_RD] = sts_clr_i[ST_UDE];
  assign ptr_clr[SRC_WR] = sts_clr_i[ST_ADPE];

  always_comb begin
    sts_set          = '0;
    sts_set[ST_MDPE] = (rd_err_i | wr_perr_i) & perr_rsp_en_i;
    sts_set[ST_DPE]  = rd_err_i;
    sts_set[ST_UDE]  = rd_err_i;
    sts_set[ST_ADPE] = wr_perr_i;
    sts_set[ST_SSE]  = sse_set;
    sts_set[ST_FED]  = (ev & sev) != '0;
    sts_set[ST_NFED] = (ev & ~sev) != '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) perr_o <= 1'b0;
    else         perr_o <= rd_err_i & perr_rsp_en_i;
  end

  err_sts_bank #(.N(ST_N)) i_sts (
    .clk_i, .rst_ni, .set_i(sts_set), .clr_i(sts_clr_i), .q_o(sts_o)
  );

  err_hdr_log #(.HDR_W(HDR_W)) i_log (
    .clk_i, .rst_ni, .cap_i(ev & ~mask), .ptr_clr_i(ptr_clr), .hdr_i,
    .fep_vld_o, .fep_idx_o, .hdr_o(hdr_log_o)
  );

  err_msg_gen i_msg (
    .clk_i, .rst_ni, .ev_i(ev), .mask_i(mask), .sev_i(sev), .serr_en_i,
    .fatal_en_i(fatal_rpt_en_i), .nonfatal_en_i(nonfatal_rpt_en_i),
    .ack_i(msg_ack_i), .sse_set_o(sse_set), .req_o(msg_req_o), .fatal_o(msg_fatal_o)
  );

  err_cpl_track i_cpl (
    .clk_i, .rst_ni, .rd_err_i, .rd_done_i, .wr_perr_i, .wr_done_i, .wr_data_xfer_i,
    .cpl_vld_o, .cpl_ur_o, .cpl_poison_o
  );

  // R2
  perr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> $past(rd_err_i && perr_rsp_en_i));
  // R6
  sse_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[ST_SSE]) |-> ($past(serr_en_i) && $rose(msg_req_o) || $past(serr_en_i && msg_req_o)));
  // R3
  adpe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_perr_i |=> sts_o[ST_ADPE]);
endmodule

// File: tb/test_sec_data_err_rpt.sv
module test_sec_data_err_rpt;
  localparam int CLK_T = 10;
  localparam int HW    = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rd_err, rd_done, wr_perr, wr_done, wr_xfer;
  logic [HW-1:0] hdr;
  logic perr_en, serr_en, fen, nfen, umask, usev, amask, asev, ack;
  logic [6:0] clr;
  logic [6:0] sts;
  logic fep_vld, fep_idx, perr, mreq, mfat, cvld, cur, cpois;
  logic [HW-1:0] hlog;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // model state
  logic [6:0] m_sts;
  logic m_vld, m_idx, m_perr, m_req, m_fat, m_cvld, m_cur, m_cpois, m_rf, m_wf;
  logic [HW-1:0] m_hdr;

  always #(CLK_T/2) clk = ~clk;

  sec_data_err_rpt #(.HDR_W(HW)) i_sec_data_err_rpt (
    .clk_i(clk), .rst_ni, .rd_err_i(rd_err), .rd_done_i(rd_done), .wr_perr_i(wr_perr),
    .wr_done_i(wr_done), .wr_data_xfer_i(wr_xfer), .hdr_i(hdr), .perr_rsp_en_i(perr_en),
    .serr_en_i(serr_en), .fatal_rpt_en_i(fen), .nonfatal_rpt_en_i(nfen),
    .ude_mask_i(umask), .ude_sev_i(usev), .adpe_mask_i(amask), .adpe_sev_i(asev),
    .sts_clr_i(clr), .msg_ack_i(ack), .sts_o(sts), .fep_vld_o(fep_vld), .fep_idx_o(fep_idx),
    .hdr_log_o(hlog), .perr_o(perr), .msg_req_o(mreq), .msg_fatal_o(mfat),
    .cpl_vld_o(cvld), .cpl_ur_o(cur), .cpl_poison_o(cpois)
  );

  task automatic chk(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic msg_of(input logic ev, input logic m, input logic s);
    return ev & ~m & (serr_en | (s ? fen : nfen));
  endfunction

  // next model state from current inputs
  task automatic model_step();
    logic g_rd, g_wr, any, gf, keep, veff, ru, wu;
    logic [6:0] set;
    g_rd = msg_of(rd_err, umask, usev);
    g_wr = msg_of(wr_perr, amask, asev);
    any  = g_rd | g_wr;
    gf   = (g_rd & usev) | (g_wr & asev);
    set    = '0;
    set[0] = (rd_err | wr_perr) & perr_en;
    set[1] = rd_err;
    set[2] = rd_err;
    set[3] = wr_perr;
    set[4] = any & serr_en;
    set[5] = (rd_err & usev) | (wr_perr & asev);
    set[6] = (rd_err & ~usev) | (wr_perr & ~asev);
    ru = rd_err & ~umask;
    wu = wr_perr & ~amask;
    veff = m_vld & ~(m_idx ? clr[3] : clr[2]);
    if (!veff && (ru || wu)) begin
      m_vld = 1'b1; m_idx = ru ? 1'b0 : 1'b1; m_hdr = hdr;
    end else m_vld = veff;
    m_sts  = set | (m_sts & ~clr);
    m_perr = rd_err & perr_en;
    keep = m_req & ~ack;
    if (any) begin m_fat = (keep & m_fat) | gf; m_req = 1'b1; end
    else if (ack) begin m_req = 1'b0; m_fat = 1'b0; end
    m_cvld  = rd_done | wr_done;
    m_cpois = rd_done & (m_rf | rd_err);
    m_cur   = ~rd_done & wr_done & (m_wf | wr_perr) & wr_xfer;
    m_rf = rd_done ? 1'b0 : (m_rf | rd_err);
    m_wf = wr_done ? 1'b0 : (m_wf | wr_perr);
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " R2 R3 mdpe"}, HW'(sts[0]), HW'(m_sts[0]));
    chk({tag, " R2 dpe"},     HW'(sts[1]), HW'(m_sts[1]));
    chk({tag, " R2 R7 ude"},  HW'(sts[2]), HW'(m_sts[2]));
    chk({tag, " R3 R7 adpe"}, HW'(sts[3]), HW'(m_sts[3]));
    chk({tag, " R6 sse"},     HW'(sts[4]), HW'(m_sts[4]));
    chk({tag, " R2 R3 fed"},  HW'(sts[5]), HW'(m_sts[5]));
    chk({tag, " R2 R3 nfed"}, HW'(sts[6]), HW'(m_sts[6]));
    chk({tag, " R4 R8 fep_vld"}, HW'(fep_vld), HW'(m_vld));
    chk({tag, " R4 fep_idx"},    HW'(fep_idx), HW'(m_idx));
    chk({tag, " R4 hdr_log"},    hlog, m_hdr);
    chk({tag, " R2 perr"},       HW'(perr), HW'(m_perr));
    chk({tag, " R5 msg_req"},    HW'(mreq), HW'(m_req));
    chk({tag, " R5 msg_fatal"},  HW'(mfat), HW'(m_fat));
    chk({tag, " R9 cpl_vld"},    HW'(cvld), HW'(m_cvld));
    chk({tag, " R11 cpl_ur"},    HW'(cur), HW'(m_cur));
    chk({tag, " R9 R10 poison"}, HW'(cpois), HW'(m_cpois));
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    cmp_all(tag);
    rd_err = 0; rd_done = 0; wr_perr = 0; wr_done = 0; clr = '0; ack = 0;
  endtask

  task automatic set_ctl(input logic [7:0] c);
    {perr_en, serr_en, fen, nfen, umask, usev, amask, asev} = c;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rd_err = 0; rd_done = 0; wr_perr = 0; wr_done = 0; wr_xfer = 0; hdr = '0;
    clr = '0; ack = 0; set_ctl(8'h00);
    m_sts = '0; m_vld = 0; m_idx = 0; m_hdr = '0; m_perr = 0; m_req = 0; m_fat = 0;
    m_cvld = 0; m_cur = 0; m_cpois = 0; m_rf = 0; m_wf = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cmp_all("R1 reset");

    // read error, all enables, fatal
    set_ctl(8'b1111_0100); rd_err = 1; hdr = 32'hA5A5_0001; tick("dir rd");
    chk("R2 perr pulse", HW'(perr), 1);
    tick("dir idle");
    chk("R2 perr one cycle", HW'(perr), 0);
    // pointer held: new error must not overwrite
    wr_perr = 1; hdr = 32'h0BAD_0002; tick("dir hold");
    chk("R4 log held", hlog, 32'hA5A5_0001);
    // clear pointed bit together with simultaneous read and write error: read wins
    ack = 1; tick("dir ack");
    clr = 7'b000_0100; tick("dir clr ude");
    chk("R8 pointer dropped", HW'(fep_vld), 0);
    rd_err = 1; wr_perr = 1; hdr = 32'h1234_5678; tick("dir both");
    chk("R4 read priority", HW'(fep_idx), 0);
    // set wins over clear
    rd_err = 1; clr = 7'b111_1111; tick("dir setclr");
    chk("R7 set wins", HW'(sts[2]), 1);
    // split: poisoned completion then clean one
    rd_err = 1; tick("dir sp err"); rd_done = 1; tick("dir sp done1");
    chk("R9 poison", HW'(cpois), 1);
    chk("R9 status SC", HW'(cur), 0);
    rd_done = 1; tick("dir sp done2");
    chk("R10 next split clean", HW'(cpois), 0);
    // write with data transfer after parity -> UR
    wr_perr = 1; tick("dir wr err"); wr_done = 1; wr_xfer = 1; tick("dir wr done");
    chk("R11 UR", HW'(cur), 1);
    // masked, perr disabled: no message, no mdpe
    clr = 7'h7f; ack = 1; tick("dir clrall");
    set_ctl(8'b0000_1010); rd_err = 1; tick("dir masked");
    chk("R5 masked no msg", HW'(mreq), 0);
    chk("R2 mdpe gated", HW'(sts[0]), 0);

    for (int c = 0; c < 4000; c++) begin
      if (c % 32 == 0) set_ctl(8'($urandom));
      rd_err  = ($urandom % 4) == 0;
      wr_perr = ($urandom % 5) == 0;
      case ($urandom % 6)
        0: rd_done = 1;
        1: wr_done = 1;
        default: ;
      endcase
      wr_xfer = $urandom % 2;
      hdr     = $urandom;
      clr     = (($urandom % 6) == 0) ? 7'($urandom) : '0;
      ack     = ($urandom % 3) == 0;
      tick("rnd");
    end
    done_flag = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule